// File: doc/BRIEF.md
# Start-up and Brownout Memory Access Guard

This block sits between a memory controller and an external non-volatile memory with SRAM-style strobes. It watches two digital level indicators: one says the supply sits above its minimum operating level, the other says the supply has dropped below the level where the memory stops accepting writes. Both arrive asynchronously and are synchronized inside the block before use.

From reset, and again after any loss of supply-good, the guard holds the active-low chip-enable and write-enable strobes high. It tells the controller that access is not allowed by keeping `access_ready` low. Once supply-good has been steady for a full start-up interval, given in clock cycles, the guard raises `access_ready` and passes the controller's strobes straight through. A brownout re-arms the whole interval; it does not resume a partial count. If supply is lost while the controller has chip-enable asserted, the guard drops the strobes at once and raises a sticky abort flag. That flag stays up until access is granted again.

There is no data path. All pins are plain control and status levels, so no valid/ready handshake and no back-pressure apply.

Top module: `pwr_access_guard`

## Requirements
- R1: While `rst_n` is low, `access_ready` is 0, `mem_ce_n` and `mem_we_n` are 1, and `access_aborted` is 0.
- R2: Whenever `access_ready` is 0, `mem_ce_n` and `mem_we_n` are both 1, whatever the controller drives.
- R3: If `supply_ok_async` rises and stays high, `access_ready` is still 0 after the (STARTUP_CYCLES+2)th rising clock edge that follows, and is 1 after the (STARTUP_CYCLES+3)th. This covers two synchronizer stages, one edge to enter the wait, and STARTUP_CYCLES edges of waiting.
- R4: If `supply_ok_async` drops during the start-up wait, the count is discarded. After supply-good returns, the full timing of R3 applies again from the new rising edge.
- R5: While access is granted, a drop of `supply_ok_async` clears `access_ready` and forces both strobes high after the second rising edge that follows. A full start-up wait is then needed before `access_ready` rises again.
- R6: When `wr_inhibit_async` is 1, `mem_we_n` is 1 from the second rising edge after it rises, in every state. `mem_ce_n` and `access_ready` are not affected. When it falls, write-enable pass-through resumes two edges later.
- R7: While `access_ready` is 1 and no inhibit is active, `mem_ce_n` equals `ctl_ce_n` and `mem_we_n` equals `ctl_we_n` in the same cycle.
- R8: `access_aborted` goes to 1 one edge after `access_ready` falls, if `ctl_ce_n` was 0 when supply loss was detected. It stays 1 until the edge on which `access_ready` rises again, where it returns to 0. A loss with `ctl_ce_n` at 1 leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok_async | input | 1 | Supply above minimum operating level (asynchronous) |
| wr_inhibit_async | input | 1 | Supply below write-inhibit level (asynchronous, 1 = inhibit) |
| ctl_ce_n | input | 1 | Controller chip enable, active low |
| ctl_we_n | input | 1 | Controller write enable, active low |
| mem_ce_n | output | 1 | Chip enable to memory, active low |
| mem_we_n | output | 1 | Write enable to memory, active low |
| access_ready | output | 1 | Memory access allowed |
| access_aborted | output | 1 | Sticky flag: an access was cut by supply loss |

## Verification
The bench builds the guard with STARTUP_CYCLES set to 20 instead of the default of 200000 (2 ms at 100 MHz). With that value the exact edge on which `access_ready` rises can be checked, repeatedly and within a short run. The short interval also makes room for a brownout partway through the wait, an abort during an active cycle, and a loss while the controller is idle. The synchronizer depth stays at its default of two, so every latency in the requirements is checked as written.

// File: rtl/pag_pkg.sv
package pag_pkg;
  typedef enum logic [1:0] {
    PAG_BLOCKED = 2'd0,
    PAG_WAITING = 2'd1,
    PAG_READY   = 2'd2
  } pag_state_e;
endpackage

// File: rtl/pag_sync.sv
module pag_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[gi] <= RESET_VAL;
        else if (gi == 0) chain[gi] <= d_async;
        else chain[gi] <= chain[(gi == 0) ? 0 : gi-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pag_startup_timer.sv
module pag_startup_timer #(
  parameter int LIMIT = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!run || done) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == LAST);
endmodule

// File: rtl/pag_fsm.sv
module pag_fsm
  import pag_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sup_ok,
  input  logic       wait_done,
  input  logic       ctl_ce_n,
  output pag_state_e state,
  output logic       aborted
);
  pag_state_e nxt;

  always_comb begin
    nxt = state;
    if (!sup_ok) nxt = PAG_BLOCKED;
    else begin
      unique case (state)
        PAG_BLOCKED: nxt = PAG_WAITING;
        PAG_WAITING: if (wait_done) nxt = PAG_READY;
        PAG_READY:   nxt = PAG_READY;
        default:     nxt = PAG_BLOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= PAG_BLOCKED;
      aborted <= 1'b0;
    end else begin
      state <= nxt;
      if (state == PAG_READY && !sup_ok && !ctl_ce_n) aborted <= 1'b1;
      else if (nxt == PAG_READY && state != PAG_READY) aborted <= 1'b0;
    end
  end
endmodule

// File: rtl/pwr_access_guard.sv
module pwr_access_guard
  import pag_pkg::*;
#(
  parameter int STARTUP_CYCLES = 200000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_async,
  input  logic wr_inhibit_async,
  input  logic ctl_ce_n,
  input  logic ctl_we_n,
  output logic mem_ce_n,
  output logic mem_we_n,
  output logic access_ready,
  output logic access_aborted
);
  logic       sup_s;
  logic       inh_s;
  logic       wait_done;
  pag_state_e state;

  pag_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_sup (
    .clk(clk), .rst_n(rst_n), .d_async(supply_ok_async), .q(sup_s)
  );

  pag_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_inh (
    .clk(clk), .rst_n(rst_n), .d_async(wr_inhibit_async), .q(inh_s)
  );

  pag_startup_timer #(.LIMIT(STARTUP_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .run(state == PAG_WAITING && sup_s),
    .done(wait_done)
  );

  pag_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sup_ok(sup_s), .wait_done(wait_done),
    .ctl_ce_n(ctl_ce_n), .state(state), .aborted(access_aborted)
  );

  // Loss of synchronized supply-good blocks in the same cycle it is seen.
  assign access_ready = (state == PAG_READY) && sup_s;
  assign mem_ce_n     = ctl_ce_n | ~access_ready;
  assign mem_we_n     = ctl_we_n | ~access_ready | inh_s;
endmodule

// File: rtl/pag_checker.sv
module pag_checker
  import pag_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sup_s,
  input logic       inh_s,
  input pag_state_e state,
  input logic       ctl_ce_n,
  input logic       ctl_we_n,
  input logic       mem_ce_n,
  input logic       mem_we_n,
  input logic       access_ready,
  input logic       access_aborted
);
  always_comb begin
    if (!rst_n) a_r1_reset_outputs: assert (!access_ready && mem_ce_n && mem_we_n);
  end

  a_r2_blocked_strobes_high: assert property (@(posedge clk) disable iff (!rst_n)
    !access_ready |-> (mem_ce_n && mem_we_n));

  a_r3_ready_only_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(access_ready) |-> $past(state) == PAG_WAITING);

  a_r5_loss_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_s |-> !access_ready);

  a_r5_no_resume_without_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PAG_BLOCKED) |=> !access_ready);

  a_r6_inhibit_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    inh_s |-> mem_we_n);

  a_r7_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (access_ready && !inh_s) |-> (mem_ce_n == ctl_ce_n && mem_we_n == ctl_we_n));

  a_r8_abort_only_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(access_aborted) |-> !access_ready);
endmodule

bind pwr_access_guard pag_checker u_pag_checker (
  .clk(clk), .rst_n(rst_n), .sup_s(sup_s), .inh_s(inh_s), .state(state),
  .ctl_ce_n(ctl_ce_n), .ctl_we_n(ctl_we_n), .mem_ce_n(mem_ce_n),
  .mem_we_n(mem_we_n), .access_ready(access_ready),
  .access_aborted(access_aborted)
);

// File: tb/pwr_access_guard_bench.sv
module pwr_access_guard_bench;
  localparam int LIMIT = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok_async = 1'b0;
  logic wr_inhibit_async = 1'b1;
  logic ctl_ce_n = 1'b1;
  logic ctl_we_n = 1'b1;
  logic mem_ce_n, mem_we_n, access_ready, access_aborted;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pwr_access_guard #(.STARTUP_CYCLES(LIMIT), .SYNC_STAGES(2)) u_pwr_access_guard (
    .clk(clk), .rst_n(rst_n), .supply_ok_async(supply_ok_async),
    .wr_inhibit_async(wr_inhibit_async), .ctl_ce_n(ctl_ce_n), .ctl_we_n(ctl_we_n),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .access_ready(access_ready),
    .access_aborted(access_aborted)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Raise supply from blocked state and wait for grant (R3 timing).
  task automatic bring_up();
    supply_ok_async = 1'b1;
    edges(LIMIT + 3);
  endtask

  task automatic t_reset();
    supply_ok_async = 1'b1;
    wr_inhibit_async = 1'b0;
    ctl_ce_n = 1'b0;
    ctl_we_n = 1'b0;
    edges(3);
    chk("R1", "ready in reset", access_ready, 1'b0);
    chk("R1", "ce in reset", mem_ce_n, 1'b1);
    chk("R1", "we in reset", mem_we_n, 1'b1);
    chk("R1", "aborted in reset", access_aborted, 1'b0);
    supply_ok_async = 1'b0;
    ctl_ce_n = 1'b1;
    ctl_we_n = 1'b1;
    rst_n = 1'b1;
    edges(4);
  endtask

  task automatic t_powerup();
    ctl_ce_n = 1'b0;
    ctl_we_n = 1'b0;
    supply_ok_async = 1'b1;
    edges(5);
    chk("R2", "ce forced high while waiting", mem_ce_n, 1'b1);
    chk("R2", "we forced high while waiting", mem_we_n, 1'b1);
    edges(LIMIT - 3);
    chk("R3", "ready one edge early", access_ready, 1'b0);
    chk("R2", "ce forced one edge early", mem_ce_n, 1'b1);
    edges(1);
    chk("R3", "ready on time", access_ready, 1'b1);
    chk("R7", "ce pass low", mem_ce_n, 1'b0);
    chk("R7", "we pass low", mem_we_n, 1'b0);
    ctl_we_n = 1'b1;
    #1;
    chk("R7", "we pass high", mem_we_n, 1'b1);
    chk("R7", "ce still low", mem_ce_n, 1'b0);
    ctl_ce_n = 1'b1;
    #1;
    chk("R7", "ce pass high", mem_ce_n, 1'b1);
    chk("R8", "no abort after clean start", access_aborted, 1'b0);
  endtask

  task automatic t_inhibit();
    ctl_ce_n = 1'b0;
    ctl_we_n = 1'b0;
    wr_inhibit_async = 1'b1;
    edges(1);
    chk("R6", "we before inhibit seen", mem_we_n, 1'b0);
    edges(1);
    chk("R6", "we inhibited", mem_we_n, 1'b1);
    chk("R6", "ce unaffected", mem_ce_n, 1'b0);
    chk("R6", "ready unaffected", access_ready, 1'b1);
    wr_inhibit_async = 1'b0;
    edges(2);
    chk("R6", "we restored", mem_we_n, 1'b0);
    ctl_ce_n = 1'b1;
    ctl_we_n = 1'b1;
  endtask

  task automatic t_brownout_abort();
    ctl_ce_n = 1'b0;
    ctl_we_n = 1'b0;
    supply_ok_async = 1'b0;
    edges(1);
    chk("R5", "ready before loss seen", access_ready, 1'b1);
    chk("R5", "ce before loss seen", mem_ce_n, 1'b0);
    edges(1);
    chk("R5", "ready dropped", access_ready, 1'b0);
    chk("R5", "ce forced high", mem_ce_n, 1'b1);
    chk("R5", "we forced high", mem_we_n, 1'b1);
    chk("R8", "abort not yet", access_aborted, 1'b0);
    edges(1);
    chk("R8", "abort set", access_aborted, 1'b1);
    ctl_ce_n = 1'b1;
    ctl_we_n = 1'b1;
    edges(3);
    supply_ok_async = 1'b1;
    edges(LIMIT + 2);
    chk("R5", "full wait after brownout", access_ready, 1'b0);
    chk("R8", "abort held", access_aborted, 1'b1);
    edges(1);
    chk("R5", "ready after brownout", access_ready, 1'b1);
    chk("R8", "abort cleared on grant", access_aborted, 1'b0);
  endtask

  task automatic t_mid_wait_drop();
    supply_ok_async = 1'b0;
    edges(4);
    supply_ok_async = 1'b1;
    edges(LIMIT / 2);
    chk("R4", "not ready mid wait", access_ready, 1'b0);
    supply_ok_async = 1'b0;
    edges(4);
    supply_ok_async = 1'b1;
    edges(LIMIT + 2);
    chk("R4", "count restarted", access_ready, 1'b0);
    edges(1);
    chk("R4", "ready after restart", access_ready, 1'b1);
  endtask

  task automatic t_idle_loss();
    ctl_ce_n = 1'b1;
    supply_ok_async = 1'b0;
    edges(4);
    chk("R8", "idle loss no abort", access_aborted, 1'b0);
    chk("R5", "idle loss not ready", access_ready, 1'b0);
    bring_up();
    chk("R3", "regrant after idle loss", access_ready, 1'b1);
    chk("R8", "still no abort", access_aborted, 1'b0);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_powerup();
    t_inhibit();
    t_brownout_abort();
    t_mid_wait_drop();
    t_idle_loss();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule